// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

A memory-mapped watchdog for a 32-bit register bus. A down-counter is loaded from a reload register and counts either on every bus clock or on a slower tick that a prescaler derives from the bus clock. Software proves it is still alive by writing one exact key word to the restart register. Any other write to that register is ignored. If the counter expires while running, the block performs the actions software has enabled. It can raise an interrupt, request a reset of a selected domain, drive an external trigger whose length is programmable, and record that the next boot should come from the secondary image. The counter then reloads and keeps running.

Reads return data in the same cycle as the address. Writes take effect at the clock edge on which `busWe` is sampled high. Reset distribution and pad drivers sit outside the block.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the count reads RELOAD_RST, control and status read 0, and irqPulse, rstReq, rstMode, extTrig and bootAlt are all low.
- R2: Writing the full word 0x0000_4755 to offset 0x08 loads the count from the reload register. Any other value written there leaves the count unchanged, including a word whose low 16 bits match and whose upper bits do not.
- R3: A write to the reload register (offset 0x04) does not alter the count until the next keyed restart.
- R4: Control bit 0 enables counting. Clearing it freezes the count at its current value, and setting it again resumes the count from that value.
- R5: With control bit 4 clear, the count drops by one on each bus clock. The running count reaching zero is not yet an expiry. The expiry happens on the next decrement step after the count reaches zero, which is N+1 steps after a restart with reload N. The count then reloads, so expiries repeat every N+1 steps.
- R6: With control bit 4 set, the count steps once every PRESCALE bus clocks, so expiries repeat every (N+1)·PRESCALE cycles.
- R7: On expiry, irqPulse rises for one cycle if control bit 2 is set. rstReq rises for one cycle if control bit 1 is set. During that cycle rstMode carries control bits 6:5, which select the domain: 0 for the SoC, 1 for the full chip, 2 for the CPU only. At all other times rstMode is 0.
- R8: On expiry with control bit 3 set, extTrig stays high for W+1 cycles. W is the low PW_W bits of the pulse-width register at offset 0x18.
- R9: Status bit 0 (offset 0x10) sets on any expiry. Status bit 1 sets on an expiry that happens while control bit 7 is set. Writing 1 to a status bit clears it. bootAlt follows status bit 1.
- R10: The register layout is: count (read only) at 0x00, reload at 0x04, restart at 0x08 (reads 0), control at 0x0C, status at 0x10, and pulse width at 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irqPulse | output | 1 | One-cycle interrupt on expiry |
| rstReq | output | 1 | One-cycle reset request on expiry |
| rstMode | output | 2 | Reset domain code while rstReq is high |
| extTrig | output | 1 | External trigger with programmable length |
| bootAlt | output | 1 | Level requesting a boot from the secondary image |

## Verification
The hardest case to reach from the ports is slow-tick mode, because the prescaler runs freely and its phase cannot be seen when the restart lands. The bench therefore accepts a window of PRESCALE cycles for the first expiry, and it requires the gap to the second expiry to be exactly (N+1)·PRESCALE cycles. A second difficult case is the moment counting stops. The control write that clears enable still sees a decrement on its own edge. The bench counts every edge from the enabling write so that it can predict the exact frozen value.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int DATA_W = 32;

  // Register byte offsets
  localparam logic [7:0] OFS_COUNT  = 8'h00;
  localparam logic [7:0] OFS_RELOAD = 8'h04;
  localparam logic [7:0] OFS_KICK   = 8'h08;
  localparam logic [7:0] OFS_CTRL   = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_PULSE  = 8'h18;

  localparam logic [DATA_W-1:0] KICK_WORD = 32'h0000_4755;

  // Control register, bit 7 down to bit 0
  typedef struct packed {
    logic       altBoot;
    logic [1:0] rstMode;
    logic       slowTick;
    logic       extEn;
    logic       irqEn;
    logic       rstEn;
    logic       run;
  } wdtCtrl_t;

  // Strobes from control to counter datapath
  typedef struct packed {
    logic restart;
    logic run;
    logic slowTick;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_keyed_pkg::*;
#(
  parameter int               CNT_W      = 32,
  parameter int               PRESCALE   = 100,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strb,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] countVal,
  output logic             expireEvt
);
  logic slowPulse;
  logic tick;
  logic [CNT_W-1:0] cntQ;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PS_W = $clog2(PRESCALE);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
      logic [PS_W-1:0] divQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               divQ <= '0;
        else if (divQ == PS_LAST) divQ <= '0;
        else                     divQ <= divQ + 1'b1;
      end
      assign slowPulse = (divQ == PS_LAST);
    end else begin : g_nodiv
      assign slowPulse = 1'b1;
    end
  endgenerate

  assign tick      = strb.slowTick ? slowPulse : 1'b1;
  assign expireEvt = strb.run && tick && (cntQ == '0) && !strb.restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= RELOAD_RST;
    end else if (strb.restart) begin
      cntQ <= reloadVal;
    end else if (strb.run && tick) begin
      if (cntQ == '0) cntQ <= reloadVal;
      else            cntQ <= cntQ - 1'b1;
    end
  end

  assign countVal = cntQ;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_keyed_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               CNT_W      = 32,
  parameter int               PW_W       = 8,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  countVal,
  input  logic              expireEvt,
  output wdtStrobe_t        strb,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              irqPulse,
  output logic              rstReq,
  output logic [1:0]        rstMode,
  output logic              extTrig,
  output logic              bootAlt
);
  wdtCtrl_t         ctrlQ;
  logic [CNT_W-1:0] reloadQ;
  logic [1:0]       statQ;
  logic [PW_W-1:0]  pulseQ;
  logic [PW_W-1:0]  extLeft;

  logic selReload, selKick, selCtrl, selStat, selPulse;
  assign selReload = busWe && (busAddr == ADDR_W'(OFS_RELOAD));
  assign selKick   = busWe && (busAddr == ADDR_W'(OFS_KICK));
  assign selCtrl   = busWe && (busAddr == ADDR_W'(OFS_CTRL));
  assign selStat   = busWe && (busAddr == ADDR_W'(OFS_STAT));
  assign selPulse  = busWe && (busAddr == ADDR_W'(OFS_PULSE));

  assign strb.restart  = selKick && (busWdata == KICK_WORD);
  assign strb.run      = ctrlQ.run;
  assign strb.slowTick = ctrlQ.slowTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      reloadQ <= RELOAD_RST;
      pulseQ  <= '0;
    end else begin
      if (selCtrl)   ctrlQ   <= wdtCtrl_t'(busWdata[7:0]);
      if (selReload) reloadQ <= busWdata[CNT_W-1:0];
      if (selPulse)  pulseQ  <= busWdata[PW_W-1:0];
    end
  end

  // Sticky status, set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
    end else begin
      statQ[0] <= expireEvt |
                  (statQ[0] & ~(selStat & busWdata[0]));
      statQ[1] <= (expireEvt & ctrlQ.altBoot) |
                  (statQ[1] & ~(selStat & busWdata[1]));
    end
  end

  // Expiry actions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      rstReq   <= 1'b0;
      rstMode  <= 2'd0;
      extTrig  <= 1'b0;
      extLeft  <= '0;
    end else begin
      irqPulse <= expireEvt & ctrlQ.irqEn;
      rstReq   <= expireEvt & ctrlQ.rstEn;
      rstMode  <= (expireEvt & ctrlQ.rstEn) ? ctrlQ.rstMode : 2'd0;
      if (expireEvt && ctrlQ.extEn) begin
        extTrig <= 1'b1;
        extLeft <= pulseQ;
      end else if (extLeft != '0) begin
        extLeft <= extLeft - 1'b1;
      end else begin
        extTrig <= 1'b0;
      end
    end
  end

  assign bootAlt   = statQ[1];
  assign reloadVal = reloadQ;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_COUNT):  busRdata = DATA_W'(countVal);
      ADDR_W'(OFS_RELOAD): busRdata = DATA_W'(reloadQ);
      ADDR_W'(OFS_CTRL):   busRdata = {{(DATA_W-8){1'b0}}, ctrlQ};
      ADDR_W'(OFS_STAT):   busRdata = {{(DATA_W-2){1'b0}}, statQ};
      ADDR_W'(OFS_PULSE):  busRdata = DATA_W'(pulseQ);
      default:             busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               CNT_W      = 32,
  parameter int               PW_W       = 8,
  parameter int               PRESCALE   = 100,
  parameter logic [CNT_W-1:0] RELOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqPulse,
  output logic              rstReq,
  output logic [1:0]        rstMode,
  output logic              extTrig,
  output logic              bootAlt
);
  wdtStrobe_t       strb;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] reloadVal;
  logic             expireEvt;

  wdt_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PW_W(PW_W), .RELOAD_RST(RELOAD_RST)
  ) i_regs (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .countVal(countVal), .expireEvt(expireEvt),
    .strb(strb), .reloadVal(reloadVal),
    .irqPulse(irqPulse), .rstReq(rstReq), .rstMode(rstMode),
    .extTrig(extTrig), .bootAlt(bootAlt)
  );

  wdt_count #(
    .CNT_W(CNT_W), .PRESCALE(PRESCALE), .RELOAD_RST(RELOAD_RST)
  ) i_count (
    .clk(clk), .rstN(rstN),
    .strb(strb), .reloadVal(reloadVal),
    .countVal(countVal), .expireEvt(expireEvt)
  );
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_keyed_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input wdtStrobe_t       strb,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic             expireEvt,
  input logic             irqPulse,
  input logic             rstReq,
  input logic [1:0]       rstMode,
  input logic             extTrig,
  input logic             bootAlt
);
  AST_KICK_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.restart) |-> countVal == $past(reloadVal)); // R2

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.restart) |=> $stable(countVal)); // R4

  AST_EXPIRY_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    expireEvt |=> countVal == $past(reloadVal)); // R5

  AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(expireEvt)); // R7

  AST_MODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rstReq |-> rstMode == 2'd0); // R7

  AST_EXT_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extTrig) |-> $past(expireEvt)); // R8

  AST_BOOT_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bootAlt) |-> $past(expireEvt)); // R9
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .countVal(countVal),
  .reloadVal(reloadVal), .expireEvt(expireEvt), .irqPulse(irqPulse),
  .rstReq(rstReq), .rstMode(rstMode), .extTrig(extTrig), .bootAlt(bootAlt)
);

// File: tb/test_wdt_keyed.sv
`timescale 1ns/1ps
module test_wdt_keyed;
  localparam int          PS     = 4;
  localparam logic [31:0] RST_LD = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqPulse, rstReq, extTrig, bootAlt;
  logic [1:0]  rstMode;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wdt_keyed #(.ADDR_W(8), .CNT_W(32), .PW_W(8), .PRESCALE(PS), .RELOAD_RST(RST_LD))
  i_wdt_keyed (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqPulse(irqPulse),
    .rstReq(rstReq), .rstMode(rstMode), .extTrig(extTrig), .bootAlt(bootAlt)
  );

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] exp, input string what);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, what, v, exp);
  endtask

  task automatic tReset();
    rdChk(8'h00, RST_LD, "R1 count at reset");
    rdChk(8'h0C, 32'h0, "R1 control at reset");
    rdChk(8'h10, 32'h0, "R1 status at reset");
    check({irqPulse, rstReq, rstMode, extTrig, bootAlt} == '0, "R1 outputs low",
          {26'b0, irqPulse, rstReq, rstMode, extTrig, bootAlt}, 32'h0);
  endtask

  task automatic tKeyAndReload();
    wr(8'h04, 32'd20);
    rdChk(8'h00, RST_LD, "R3 reload write leaves count");
    rdChk(8'h04, 32'd20, "R10 reload readback");
    wr(8'h08, 32'h0000_1234);
    rdChk(8'h00, RST_LD, "R2 wrong key ignored");
    wr(8'h08, 32'h0001_4755);
    rdChk(8'h00, RST_LD, "R2 key with upper bits ignored");
    wr(8'h08, 32'h0000_4755);
    rdChk(8'h00, 32'd20, "R2 key loads count");
    rdChk(8'h08, 32'h0, "R10 restart reads zero");
    wr(8'h04, 32'd50);
    rdChk(8'h00, 32'd20, "R3 count kept until restart");
    wr(8'h08, 32'h0000_4755);
    rdChk(8'h00, 32'd50, "R3 new reload after restart");
  endtask

  task automatic tStopHold();
    logic [31:0] a, b;
    wr(8'h0C, 32'h01);
    repeat (5) @(posedge clk);
    wr(8'h0C, 32'h00);
    rd(8'h00, a);
    check(a == 32'd44, "R4 frozen value", a, 32'd44);
    repeat (10) @(posedge clk);
    rd(8'h00, b);
    check(b == a, "R4 count held while stopped", b, a);
    wr(8'h0C, 32'h01);
    wr(8'h0C, 32'h00);
    rd(8'h00, b);
    check(b == a - 32'd2, "R4 resumes from held value", b, a - 32'd2);
  endtask

  task automatic tFastExpiry();
    int first = 0, second = 0, rstCnt = 0;
    logic modeOk = 1'b1;
    logic [31:0] v;
    wr(8'h04, 32'd9);
    wr(8'h08, 32'h0000_4755);
    wr(8'h0C, 32'h47); // run, reset, irq, domain code 2
    for (int k = 1; k <= 22; k++) begin
      @(posedge clk); @(negedge clk);
      if (irqPulse) begin
        if (first == 0) first = k;
        else if (second == 0) second = k;
      end
      if (rstReq) begin
        rstCnt++;
        if (rstMode != 2'd2) modeOk = 1'b0;
      end
    end
    check(first == 10, "R5 first expiry after N+1 cycles", first, 10);
    check(second == 20, "R5 period N+1 after reload", second, 20);
    check(rstCnt == 2, "R7 one-cycle reset request per expiry", rstCnt, 2);
    check(modeOk, "R7 domain code 2 with reset request", modeOk, 1);
    rdChk(8'h10, 32'h1, "R9 status bit0 only");
    check(!bootAlt, "R9 no alt boot without bit7", bootAlt, 0);
    wr(8'h0C, 32'h00);
    wr(8'h10, 32'h1);
    rdChk(8'h10, 32'h0, "R9 write one clears");
    rd(8'h0C, v);
    check(v == 32'h0, "R10 control readback", v, 0);
  endtask

  task automatic tExtAndBoot();
    int first = 0, high = 0, irqSeen = 0;
    wr(8'h18, 32'd3);
    rdChk(8'h18, 32'd3, "R10 pulse width readback");
    wr(8'h04, 32'd4);
    wr(8'h08, 32'h0000_4755);
    wr(8'h0C, 32'h89); // run, ext, alt boot
    for (int k = 1; k <= 9; k++) begin
      @(posedge clk); @(negedge clk);
      if (extTrig) begin
        high++;
        if (first == 0) first = k;
      end
      if (irqPulse || rstReq) irqSeen++;
    end
    check(first == 5, "R8 trigger starts at expiry", first, 5);
    check(high == 4, "R8 trigger lasts width+1", high, 4);
    check(irqSeen == 0, "R7 disabled actions stay low", irqSeen, 0);
    rdChk(8'h10, 32'h3, "R9 both status bits");
    check(bootAlt, "R9 alt boot level", bootAlt, 1);
    wr(8'h0C, 32'h00);
    wr(8'h10, 32'h2);
    rdChk(8'h10, 32'h1, "R9 clear bit1 only");
    check(!bootAlt, "R9 alt boot cleared", bootAlt, 0);
    wr(8'h10, 32'h1);
  endtask

  task automatic tSlowTick();
    int first = 0, second = 0;
    wr(8'h04, 32'd3);
    wr(8'h08, 32'h0000_4755);
    wr(8'h0C, 32'h15); // run, irq, slow tick
    rdChk(8'h0C, 32'h15, "R10 control readback slow");
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (irqPulse) begin
        if (first == 0) first = k;
        else if (second == 0) second = k;
      end
    end
    // the control read above took one extra edge
    check(first >= 12 && first <= 16, "R6 first slow expiry window", first, 16);
    check(second - first == 16, "R6 slow period (N+1)*PRESCALE", second - first, 16);
    wr(8'h0C, 32'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    tReset();
    tKeyAndReload();
    tStopHold();
    tFastExpiry();
    tExtAndBoot();
    tSlowTick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule